// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges several reset requests into a single system reset for a small microcontroller. It runs entirely on a free-running reference clock. Four sources can request a reset: an active-low external pin, a supply-voltage monitor status line, a comparator output, and an internal detector that watches the system clock for a stall at either level. A power-on input clears the block completely.

The reset output is raised asynchronously by the pin or by power-on. Every other source raises it synchronously. The output is always released synchronously, after a programmable hold time.

A source register uses each bit for two purposes. Writing the bit arms a reset source. Reading the same bit reports whether that source caused the most recent reset. A second register arms the supply monitor and shows the live supply status. Firmware reads the cause after it restarts. The enables survive resets that firmware can recover from, and a pin reset or power-on clears them.

Top module: `rst_ctrl`

## Requirements
- R1: `sys_rst` is 1 with no clock edge needed whenever `por_n` or `ext_rst_n` is low.
- R2: Each level input passes through a `SYNC_STAGES`-flop synchronizer. After the last active source clears at the block's inputs, `sys_rst` falls on reference edge `SYNC_STAGES + HOLD_CYC` and changes on no other edge.
- R3: The source register (`rd_sel`=0) reads as follows: bit 0 is the pin flag, bit 1 the supply flag, bit 2 the clock-stall flag, bit 5 the comparator flag, and the other bits read 0. When a new reset starts, only the flag of the winning source is set. Priority is pin, then supply, then clock stall, then comparator.
- R4: Writing bit 2 of the source register as 1 arms the clock-stall detector. It requests a reset when `sys_clk` shows no edge for `MCD_LIMIT` reference cycles, whether stuck high or stuck low. A running clock, or a detector written 0, causes no reset.
- R5: Writing bit 5 of the source register as 1 arms the comparator. While armed, `cmp_out` low requests a reset.
- R6: The supply monitor requests a reset on `vdd_ok` low only when both conditions hold: bit 7 of the supply register is 1 and bit 1 of the source register is 1.
- R7: In the supply register (`rd_sel`=1), bit 7 reads back the enable and bit 6 shows the synchronized `vdd_ok`. Bits 5..0 read 0. Writes to bits 6..0 have no effect.
- R8: A reset caused by the supply, the clock-stall detector or the comparator keeps the source-register enables (bits 1, 2 and 5). A pin reset clears them. The supply-register enable is cleared only by power-on.
- R9: Register writes are ignored while `sys_rst` is 1.
- R10: After `por_n` rises, all flags read 0 and `sys_rst` falls on the `HOLD_CYC`-th reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| sys_clk | input | 1 | Monitored system clock |
| vdd_ok | input | 1 | Supply status, 1 = above threshold |
| cmp_out | input | 1 | Comparator output, 0 requests reset when armed |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 source register, 1 supply register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 source register, 1 supply register |
| rd_data | output | 8 | Read data |
| sys_rst | output | 1 | System reset, active high |

## Verification
Several reset requests can reach the synchronizers in the same reference cycle. The flag logic must then choose exactly one cause. The bench drives every combination of pin, supply and comparator on the same falling edge. It then reads the source register and expects the single bit computed from the priority order. A register write can also coincide with an active reset. The bench issues a disarming write during a comparator reset, then shows at the reset output that the comparator stays armed.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;

    typedef struct packed {
        logic pin;
        logic sup;
        logic mcd;
        logic cmp;
    } src_t;

    localparam int SRC_PIN_BIT  = 0;
    localparam int SRC_SUP_BIT  = 1;
    localparam int SRC_MCD_BIT  = 2;
    localparam int SRC_CMP_BIT  = 5;
    localparam int SUP_EN_BIT   = 7;
    localparam int SUP_STAT_BIT = 6;

    // fixed priority: pin > supply > clock stall > comparator
    function automatic src_t pick_winner(input src_t act);
        src_t w;
        w = '0;
        if (act.pin)      w.pin = 1'b1;
        else if (act.sup) w.sup = 1'b1;
        else if (act.mcd) w.mcd = 1'b1;
        else if (act.cmp) w.cmp = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
`timescale 1ns/1ps
module rstc_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rstc_clkmon.sv
`timescale 1ns/1ps
module rstc_clkmon #(
    parameter int LIMIT  = 5000,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    input  logic mon_clk,
    output logic stuck
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    mon_s;

    rstc_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
        .clk(clk), .arst_n(arst_n), .d(mon_clk), .q(mon_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = mon_s;
        if (!en || (mon_s != st_q.prev)) st_d.cnt = '0;
        else if (st_q.cnt != LIM_V)      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stuck = en && (st_q.cnt == LIM_V);
endmodule

// File: rtl/rst_ctrl.sv
`timescale 1ns/1ps
module rst_ctrl
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int MCD_LIMIT   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       sys_clk,
    input  logic       vdd_ok,
    input  logic       cmp_out,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       sys_rst
);
    localparam int HCW = $clog2(HOLD_CYC) + 1;
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

    typedef struct packed {
        logic           in_rst;
        logic [HCW-1:0] cnt;
        src_t           cause;
        logic           mcd_en;
        logic           cmp_en;
        logic           sup_sel;
        logic           sup_en;
    } ctl_st_t;

    ctl_st_t    st_d, st_q;
    logic [2:0] lvl_s;
    logic       pin_s, vdd_s, cmp_s;
    logic       mcd_stuck;
    src_t       act;
    logic       any_act;
    logic       unused_wr;

    assign unused_wr = ^{wr_data[6], wr_data[4:3], wr_data[0]};

    rstc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_lvl_sync (
        .clk(ref_clk), .arst_n(por_n),
        .d({ext_rst_n, vdd_ok, cmp_out}), .q(lvl_s)
    );
    assign {pin_s, vdd_s, cmp_s} = lvl_s;

    rstc_clkmon #(.LIMIT(MCD_LIMIT), .STAGES(SYNC_STAGES)) u_clkmon (
        .clk(ref_clk), .arst_n(por_n), .en(st_q.mcd_en),
        .mon_clk(sys_clk), .stuck(mcd_stuck)
    );

    assign sys_rst = st_q.in_rst | ~ext_rst_n | ~por_n;

    always_comb begin
        act.pin = ~pin_s;
        act.sup = st_q.sup_en & st_q.sup_sel & ~vdd_s;
        act.mcd = mcd_stuck;
        act.cmp = st_q.cmp_en & ~cmp_s;
        any_act = |act;
    end

    always_comb begin
        st_d = st_q;
        if (any_act) begin
            st_d.in_rst = 1'b1;
            st_d.cnt    = '0;
            if (!st_q.in_rst) begin
                st_d.cause = pick_winner(act);
                if (act.pin) begin
                    st_d.mcd_en  = 1'b0;
                    st_d.cmp_en  = 1'b0;
                    st_d.sup_sel = 1'b0;
                end
            end
        end else if (st_q.in_rst) begin
            if (st_q.cnt == HOLD_LAST) st_d.in_rst = 1'b0;
            else                       st_d.cnt    = st_q.cnt + 1'b1;
        end else if (wr_en && !sys_rst) begin
            if (!wr_sel) begin
                st_d.sup_sel = wr_data[SRC_SUP_BIT];
                st_d.mcd_en  = wr_data[SRC_MCD_BIT];
                st_d.cmp_en  = wr_data[SRC_CMP_BIT];
            end else begin
                st_d.sup_en  = wr_data[SUP_EN_BIT];
            end
        end
    end

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            st_q        <= '0;
            st_q.in_rst <= 1'b1;
        end else begin
            st_q        <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[SUP_EN_BIT]   = st_q.sup_en;
            rd_data[SUP_STAT_BIT] = vdd_s;
        end else begin
            rd_data[SRC_PIN_BIT] = st_q.cause.pin;
            rd_data[SRC_SUP_BIT] = st_q.cause.sup;
            rd_data[SRC_MCD_BIT] = st_q.cause.mcd;
            rd_data[SRC_CMP_BIT] = st_q.cause.cmp;
        end
    end
endmodule

// File: rtl/rst_ctrl_chk.sv
`timescale 1ns/1ps
module rst_ctrl_chk (
    input logic       ref_clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       rd_sel,
    input logic [7:0] rd_data,
    input logic       sys_rst
);
    // R1
    pin_forces_rst_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        !ext_rst_n |-> sys_rst);

    // R3
    one_cause_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        !rd_sel |-> $onehot0({rd_data[5], rd_data[2:0]}));

    // R3
    src_spare_zero_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        !rd_sel |-> (rd_data[7:6] == 2'b00 && rd_data[4:3] == 2'b00));

    // R7
    sup_spare_zero_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        rd_sel |-> (rd_data[5:0] == 6'd0));

    // R2
    hold_min_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        $fell(sys_rst) |-> $past(sys_rst, 2));
endmodule

bind rst_ctrl rst_ctrl_chk chk_i (
    .ref_clk(ref_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .rd_sel(rd_sel), .rd_data(rd_data), .sys_rst(sys_rst)
);

// File: tb/rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_ctrl_tb_top;
    localparam int HOLD  = 4;
    localparam int LIMIT = 16;
    localparam int SYNC  = 2;

    logic       ref_clk = 1'b0;
    logic       por_n = 1'b0, ext_rst_n = 1'b1, vdd_ok = 1'b1, cmp_out = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sys_rst;
    logic       osc = 1'b0, sys_run = 1'b1, stuck_lvl = 1'b0;
    logic       sys_clk;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 ref_clk = ~ref_clk;
    always #15 osc = ~osc;
    assign sys_clk = sys_run ? osc : stuck_lvl;

    rst_ctrl #(.HOLD_CYC(HOLD), .MCD_LIMIT(LIMIT), .SYNC_STAGES(SYNC)) dut_i (
        .ref_clk(ref_clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sys_clk(sys_clk),
        .vdd_ok(vdd_ok), .cmp_out(cmp_out), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .sys_rst(sys_rst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge ref_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge ref_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic settle(input string tag);
        int k;
        ext_rst_n = 1'b1; vdd_ok = 1'b1; cmp_out = 1'b1; sys_run = 1'b1;
        k = 0;
        while (sys_rst && k < 40) begin tick(1); k++; end
        chk(!sys_rst, tag, sys_rst, 0);
        tick(2);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        int         cnt;

        // R1 / R10: power-on
        #5 chk(sys_rst === 1'b1, "R1 por", sys_rst, 1);
        tick(3);
        por_n = 1'b1;
        tick(HOLD - 1);
        chk(sys_rst === 1'b1, "R10 hold after por", sys_rst, 1);
        tick(1);
        chk(sys_rst === 1'b0, "R10 release after por", sys_rst, 0);
        rd(1'b0, v);
        chk(v == 8'h00, "R10 flags clear", v, 0);

        // R7 supply register
        rd(1'b1, v); chk(v == 8'h40, "R7 sup read", v, 8'h40);
        wr(1'b1, 8'hFF); rd(1'b1, v); chk(v == 8'hC0, "R7 sup enable", v, 8'hC0);
        wr(1'b1, 8'h7F); rd(1'b1, v); chk(v == 8'h40, "R7 low bits ignored", v, 8'h40);
        vdd_ok = 1'b0; tick(SYNC + 1);
        rd(1'b1, v); chk(v == 8'h00, "R7 status low", v, 0);
        chk(!sys_rst, "R6 unarmed supply", sys_rst, 0);
        vdd_ok = 1'b1; tick(SYNC + 1);

        // R6 gating
        wr(1'b1, 8'h80); wr(1'b0, 8'h00);
        vdd_ok = 1'b0; tick(6);
        chk(!sys_rst, "R6 enabled not selected", sys_rst, 0);
        vdd_ok = 1'b1; tick(3);
        wr(1'b1, 8'h00); wr(1'b0, 8'h02);
        vdd_ok = 1'b0; tick(6);
        chk(!sys_rst, "R6 selected not enabled", sys_rst, 0);
        vdd_ok = 1'b1; tick(3);

        // R3 priority sweep over pin, supply, comparator
        for (int m = 1; m < 8; m++) begin
            wr(1'b1, 8'h80); wr(1'b0, 8'h22);
            @(negedge ref_clk);
            ext_rst_n = ~m[2]; vdd_ok = ~m[1]; cmp_out = ~m[0];
            #1 if (m[2]) chk(sys_rst === 1'b1, "R1 pin async", sys_rst, 1);
            tick(6);
            chk(sys_rst === 1'b1, "R3 reset active", sys_rst, 1);
            ext_rst_n = 1'b1; vdd_ok = 1'b1; cmp_out = 1'b1;
            tick(HOLD + 4);
            chk(!sys_rst, "R2 released", sys_rst, 0);
            exp = m[2] ? 8'h01 : (m[1] ? 8'h02 : 8'h20);
            rd(1'b0, v);
            chk(v == exp, "R3 priority flag", v, exp);
        end

        // R2 exact hold and R5 comparator
        wr(1'b0, 8'h20);
        cmp_out = 1'b0; tick(5);
        chk(sys_rst === 1'b1, "R5 comparator reset", sys_rst, 1);
        cmp_out = 1'b1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge ref_clk);
            if (sys_rst) cnt++;
        end
        chk(cnt == SYNC + HOLD - 1, "R2 hold length", cnt, SYNC + HOLD - 1);
        rd(1'b0, v); chk(v == 8'h20, "R5 flag", v, 8'h20);

        // R8 retention across comparator reset, cleared by pin
        cmp_out = 1'b0; tick(6);
        chk(sys_rst === 1'b1, "R8 cmp enable kept", sys_rst, 1);
        settle("R8 settle a");
        ext_rst_n = 1'b0; tick(4);
        settle("R8 settle b");
        rd(1'b0, v); chk(v == 8'h01, "R3 pin flag", v, 8'h01);
        cmp_out = 1'b0; tick(6);
        chk(!sys_rst, "R8 pin clears cmp enable", sys_rst, 0);
        cmp_out = 1'b1; tick(3);
        wr(1'b0, 8'h02);
        vdd_ok = 1'b0; tick(6);
        chk(sys_rst === 1'b1, "R8 sup enable survives pin", sys_rst, 1);
        settle("R8 settle c");
        rd(1'b0, v); chk(v == 8'h02, "R6 supply flag", v, 8'h02);

        // R9 write during reset ignored
        wr(1'b0, 8'h20);
        cmp_out = 1'b0; tick(4);
        wr(1'b0, 8'h00);
        settle("R9 settle a");
        cmp_out = 1'b0; tick(6);
        chk(sys_rst === 1'b1, "R9 write ignored in reset", sys_rst, 1);
        settle("R9 settle b");

        // R4 clock-stall detector
        wr(1'b0, 8'h04);
        tick(60);
        chk(!sys_rst, "R4 running clock", sys_rst, 0);
        for (int lvl = 0; lvl < 2; lvl++) begin
            @(negedge ref_clk);
            stuck_lvl = lvl[0]; sys_run = 1'b0;
            tick(LIMIT + 10);
            chk(sys_rst === 1'b1, "R4 stuck clock reset", sys_rst, 1);
            settle("R4 settle");
            rd(1'b0, v); chk(v == 8'h04, "R4 stall flag", v, 8'h04);
        end
        wr(1'b0, 8'h00);
        @(negedge ref_clk);
        sys_run = 1'b0;
        tick(LIMIT + 20);
        chk(!sys_rst, "R4 disabled detector", sys_rst, 0);
        sys_run = 1'b1; tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule